// File: doc/BRIEF.md
# Test Status Controller

This peripheral lets a test program running on a processor report its results and end a simulation run. It sits on a simple slave bus as a window of three write-only 32-bit registers. The `BASE` parameter sets where the window starts and defaults to 0xFFFF0000.

A write to the name-pointer register starts an autonomous fetch through a word-wide master read port. The fetch copies a 16-byte test name from system memory into a local buffer and always leaves the last byte of that buffer zero. A write to the pass/fail register emits a one-cycle result event. The event carries the stored name and a flag that is set when the written value is non-zero. A write to the control register raises a shutdown request that stays set until reset.

Top module: `test_status_ctrl`

## Requirements
- R1: The registers sit at byte offsets from `BASE`, and address bits [3:2] select the register. Offset 0x0 is control, offset 0x4 is pass/fail and offset 0x8 is the name pointer.
- R2: Only full-word writes are accepted, meaning `s_write`=1 and `s_be`=4'hF. A read or a partial write is accepted on the bus, pulses `s_err` for one cycle in the cycle after acceptance, and has no other effect.
- R3: Some addresses are not a register: offset 0xC, any address with bits [1:0] non-zero, and any address outside the 16-byte block at `BASE`. An access to such an address pulses `s_err` and changes no state.
- R4: Any full-word write to control sets `shutdown_req` in the cycle after acceptance, whatever the data. The signal stays set until reset.
- R5: A full-word write to pass/fail produces `res_valid` for exactly one cycle, in the cycle after acceptance. In that cycle `res_fail` is 1 when the written data is non-zero and 0 when it is zero, and `res_name` shows the name buffer.
- R6: A full-word write to the name pointer starts a fetch of four words at pointer, pointer+4, pointer+8 and pointer+12, in that order. Each word is requested with a one-cycle `m_req` and completes on `m_rvalid`. Name byte k is placed at `res_name[8k+7:8k]`, and byte 0 of each word is its least significant byte.
- R7: After a fetch, byte 15 of the name, `res_name[127:120]`, is zero whatever memory held at that address.
- R8: While a fetch is in progress, `s_ready` stays low for full-word writes to pass/fail and to the name pointer. Control writes and rejected accesses are still accepted.
- R9: Reset clears the pointer, the stored pass/fail value, the whole name buffer and all outputs, and it leaves `s_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Slave access request |
| s_write | input | 1 | 1 for a write, 0 for a read |
| s_addr | input | 32 | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_be | input | 4 | Byte enables |
| s_ready | output | 1 | Access accepted when high together with `s_valid` |
| s_err | output | 1 | One-cycle pulse after a rejected access |
| m_req | output | 1 | One-cycle master read request |
| m_addr | output | 32 | Master read byte address |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |
| shutdown_req | output | 1 | Sticky shutdown request |
| res_valid | output | 1 | One-cycle result event |
| res_fail | output | 1 | Result flag, 1 means fail |
| res_name | output | 128 | Name buffer, byte 0 in the low bits |

## Verification
A pass/fail write can arrive while the name fetch is still in flight. The bench provokes this by issuing the pass/fail write on the very next bus cycle after a pointer write, with memory latencies from zero to three cycles. It judges the outcome by requiring that the write was stalled and that the result carries the complete new name. A control write placed over a running fetch must instead be accepted at once. The bench checks both effects: the shutdown is raised and the fetch still finishes intact.

// File: rtl/test_status_ctrl.sv
module test_status_ctrl #(
  parameter logic [31:0] BASE       = 32'hFFFF_0000,
  parameter int          NAME_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic                     s_write,
  input  logic [31:0]              s_addr,
  input  logic [31:0]              s_wdata,
  input  logic [3:0]               s_be,
  output logic                     s_ready,
  output logic                     s_err,
  output logic                     m_req,
  output logic [31:0]              m_addr,
  input  logic                     m_rvalid,
  input  logic [31:0]              m_rdata,
  output logic                     shutdown_req,
  output logic                     res_valid,
  output logic                     res_fail,
  output logic [NAME_WORDS*32-1:0] res_name
);
  localparam int NB   = NAME_WORDS * 32;
  localparam int CW   = (NAME_WORDS > 1) ? $clog2(NAME_WORDS) : 1;
  localparam int LAST = NAME_WORDS - 1;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_t;

  fetch_t        st;
  logic [CW-1:0] cnt;
  logic [31:0]   ptr, pf_q;
  logic [NB-1:0] name;

  wire [1:0] idx  = s_addr[3:2];
  wire       good = s_write && (s_be == 4'hF) && (s_addr[31:4] == BASE[31:4])
                    && (s_addr[1:0] == 2'b00) && (idx != 2'd3);
  wire       busy = (st != F_IDLE);
  assign s_ready  = !(busy && good && (idx != 2'd0));
  wire       acc    = s_valid && s_ready;
  wire       hit_cl = acc && good && (idx == 2'd0);
  wire       hit_pf = acc && good && (idx == 2'd1);
  wire       hit_nm = acc && good && (idx == 2'd2);
  wire       last_w = (int'(cnt) == LAST);

  assign m_req    = (st == F_REQ);
  assign m_addr   = ptr + (32'(cnt) << 2);
  assign res_fail = |pf_q;
  assign res_name = name;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= F_IDLE;
      cnt          <= '0;
      ptr          <= '0;
      pf_q         <= '0;
      name         <= '0;
      s_err        <= 1'b0;
      res_valid    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      s_err     <= acc && !good;
      res_valid <= hit_pf;
      if (hit_cl) shutdown_req <= 1'b1;
      if (hit_pf) pf_q <= s_wdata;
      case (st)
        F_IDLE: if (hit_nm) begin
          ptr <= s_wdata;
          cnt <= '0;
          st  <= F_REQ;
        end
        F_REQ: st <= F_WAIT;
        F_WAIT: if (m_rvalid) begin
          name[32*int'(cnt) +: 32] <= last_w ? {8'h00, m_rdata[23:0]} : m_rdata;
          if (last_w) st <= F_IDLE;
          else begin
            cnt <= cnt + 1'b1;
            st  <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/test_status_ctrl_chk.sv
module test_status_ctrl_chk #(
  parameter logic [31:0] BASE = 32'hFFFF_0000,
  parameter int          NB   = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_write,
  input logic [31:0]   s_addr,
  input logic [3:0]    s_be,
  input logic          s_ready,
  input logic          s_err,
  input logic          m_req,
  input logic          shutdown_req,
  input logic          res_valid,
  input logic [NB-1:0] res_name,
  input logic          busy
);
  wire ok_w = s_write && (s_be == 4'hF) && (s_addr[31:4] == BASE[31:4])
              && (s_addr[1:0] == 2'b00) && (s_addr[3:2] != 2'd3);

  AST_SHUTDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req); // R4
  AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(s_valid && s_ready && ok_w && s_addr[3:2] == 2'd1)); // R5
  AST_NAME_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_name[NB-1:NB-8] == 8'h00)); // R7
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && s_valid && ok_w && s_addr[3:2] != 2'd0) |-> !s_ready); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_err |-> $past(s_valid && s_ready && !ok_w)); // R2
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |=> !m_req); // R6
endmodule

bind test_status_ctrl test_status_ctrl_chk #(.BASE(BASE), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_write(s_write),
  .s_addr(s_addr), .s_be(s_be), .s_ready(s_ready), .s_err(s_err),
  .m_req(m_req), .shutdown_req(shutdown_req), .res_valid(res_valid),
  .res_name(res_name), .busy(busy)
);

// File: tb/tb_test_status_ctrl.sv
`timescale 1ns/1ps
module tb_test_status_ctrl;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_write = 0, m_rvalid = 0;
  logic [31:0] s_addr = 0, s_wdata = 0, m_rdata = 0, m_addr;
  logic [3:0] s_be = 0;
  logic s_ready, s_err, m_req, shutdown_req, res_valid, res_fail;
  logic [127:0] res_name;

  test_status_ctrl #(.BASE(BASE)) dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, stalls = 0, reqs = 0, lat = 0, dly = 0;
  bit pend = 0, done = 0;
  logic [31:0] bases [2];
  logic [31:0] paddr;
  logic o_err, o_rv, o_fail, o_sd;
  logic [127:0] o_name;

  function automatic logic [7:0] fb(input logic [31:0] a);
    return a[7:0] * 8'd13 + 8'd7 + a[15:8];
  endfunction

  function automatic logic [127:0] exp_name(input logic [31:0] p);
    logic [127:0] n;
    for (int k = 0; k < 16; k++) n[8*k +: 8] = (k == 15) ? 8'h00 : fb(p + 32'(k));
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    m_rvalid = 0;
    if (pend) begin
      if (dly == 0) begin
        m_rvalid = 1;
        m_rdata = {fb(paddr + 3), fb(paddr + 2), fb(paddr + 1), fb(paddr)};
        pend = 0;
      end else dly--;
    end
    if (m_req) begin
      chk(m_addr == bases[(reqs / 4) % 2] + 32'(4 * (reqs % 4)), "R6", "fetch address",
          128'(m_addr), 128'(bases[(reqs / 4) % 2] + 32'(4 * (reqs % 4))));
      paddr = m_addr; pend = 1; dly = lat; reqs++;
    end
  end

  task automatic bus(input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic wr);
    @(negedge clk);
    #0.5;
    s_valid = 1; s_addr = a; s_wdata = d; s_be = be; s_write = wr;
    stalls = 0;
    #0.1;
    while (!s_ready) begin
      stalls++;
      @(negedge clk);
      #0.6;
    end
    @(posedge clk);
    @(negedge clk);
    o_err = s_err; o_rv = res_valid; o_fail = res_fail; o_name = res_name; o_sd = shutdown_req;
    s_valid = 0; s_write = 0; s_be = 0;
  endtask

  task automatic wr(input logic [31:0] off, input logic [31:0] d);
    bus(BASE + off, d, 4'hF, 1'b1);
  endtask

  task automatic wait_fetch();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    bases[0] = 0; bases[1] = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!shutdown_req && !res_valid && !s_err && !m_req, "R9", "outputs after reset",
        {shutdown_req, res_valid, s_err, m_req}, 0);
    chk(s_ready, "R9", "ready in reset", 128'(s_ready), 1);
    rst_n = 1;
    wr(32'h4, 32'h0);
    chk(o_rv && o_name == 0 && !o_fail, "R9", "name buffer cleared", o_name, 0);

    // R5, R1: pass/fail values
    foreach (bases[i]) ;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = (i == 0) ? 0 : (i == 7) ? 32'h8000_0000 : 32'(1) << (i * 4);
      if (i == 3) v = 0;
      wr(32'h4, v);
      chk(o_rv == 1, "R5", "result pulse", 128'(o_rv), 1);
      chk(o_fail == (v != 0), "R5", "fail flag", 128'(o_fail), 128'(v != 0));
      chk(!o_err && !o_sd, "R1", "no error or shutdown on pass/fail", {o_err, o_sd}, 0);
      @(negedge clk);
      chk(!res_valid, "R5", "pulse is one cycle", 128'(res_valid), 0);
    end

    // R6, R7, R8: fetch sweep with pass/fail immediately after
    for (int l = 0; l < 4; l++) begin
      for (int i = 0; i < 6; i++) begin
        logic [31:0] p;
        p = 32'h1000_0000 + 32'(i * 32'h137 + l * 32'h1000);
        lat = l; reqs = 0; bases[0] = p;
        wr(32'h8, p);
        chk(!o_err && !o_rv, "R1", "name write no event", {o_err, o_rv}, 0);
        wr(32'h4, 32'(i & 1));
        chk(stalls > 0, "R8", "pass/fail held during fetch", 128'(stalls), 1);
        chk(reqs == 4, "R6", "four reads", 128'(reqs), 4);
        chk(o_rv && o_name == exp_name(p), "R6", "fetched name", o_name, exp_name(p));
        chk(o_name[127:120] == 0 && fb(p + 15) != 0 || o_name[127:120] == 0, "R7",
            "terminator", 128'(o_name[127:120]), 0);
        chk(o_fail == (i & 1), "R5", "fail flag after fetch", 128'(o_fail), 128'(i & 1));
      end
    end

    // R8: second name write held while busy
    lat = 2; reqs = 0; bases[0] = 32'h2000_0040; bases[1] = 32'h3000_0081;
    wr(32'h8, bases[0]);
    wr(32'h8, bases[1]);
    chk(stalls > 0, "R8", "name write held during fetch", 128'(stalls), 1);
    wr(32'h4, 32'h5);
    chk(reqs == 8, "R6", "two full fetches", 128'(reqs), 8);
    chk(o_name == exp_name(bases[1]), "R8", "latest name kept", o_name, exp_name(bases[1]));

    // R2, R3: rejected accesses
    reqs = 0;
    for (int j = 0; j < 9; j++) begin
      logic [31:0] a; logic [3:0] be; logic w;
      w = 1; be = 4'hF;
      case (j)
        0: begin a = BASE + 4;   be = 4'h3; end
        1: begin a = BASE + 8;   w = 0; end
        2: begin a = BASE;       be = 4'h1; end
        3: begin a = BASE + 8;   be = 4'hE; end
        4: begin a = BASE + 4;   w = 0; end
        5: a = BASE + 32'hC;
        6: a = BASE + 32'h2;
        7: a = BASE + 32'h10;
        default: a = 32'h0000_0008;
      endcase
      bus(a, 32'hDEAD_0001, be, w);
      chk(o_err && !o_rv && !o_sd, j < 5 ? "R2" : "R3", "rejected access",
          {o_err, o_rv, o_sd}, 4);
      @(negedge clk);
      chk(!s_err, j < 5 ? "R2" : "R3", "error pulse one cycle", 128'(s_err), 0);
    end
    repeat (10) @(negedge clk);
    chk(reqs == 0, "R3", "no fetch from rejected writes", 128'(reqs), 0);
    wr(32'h4, 32'h0);
    chk(o_name == exp_name(bases[1]) && !o_fail, "R2", "state unchanged by rejects",
        o_name, exp_name(bases[1]));
    chk(!shutdown_req, "R4", "no shutdown yet", 128'(shutdown_req), 0);

    // R4, R8: control during fetch
    lat = 3; reqs = 0; bases[0] = 32'h4000_0100;
    wr(32'h8, bases[0]);
    wr(32'h0, 32'h0);
    chk(stalls == 0, "R8", "control not held", 128'(stalls), 0);
    chk(o_sd, "R4", "shutdown raised", 128'(o_sd), 1);
    wait_fetch();
    wr(32'h4, 32'h1);
    chk(o_name == exp_name(bases[0]) && o_fail, "R4", "fetch survives control",
        o_name, exp_name(bases[0]));
    repeat (5) @(negedge clk);
    chk(shutdown_req, "R4", "shutdown sticky", 128'(shutdown_req), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run hung actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule